// File: doc/BRIEF.md
# Frame Sync Enable Qualifier

This block decides, once per clock, whether an external frame-sync input may be used to falling-edge align the output clocks of a timing device, and which of up to three sync pins provides it. It looks at a 4-bit source selector, the index of the reference currently chosen by the DPLL, the DPLL lock flag, an automatic-mode control and a per-pin "sync qualified" flag. It also holds the sync enable bit itself, written by software through a write strobe, and clears that bit in hardware when the rules call for it.

The source selector has two modes. When its upper two bits are not both set, only pin 1 can supply sync; with automatic mode off the enable bit alone decides, and with automatic mode on the DPLL must also be locked to the reference index named by the whole selector. When the upper two bits are both set, the lower two bits name the sync pin, and sync is enabled only while the reference paired with that pin is the selected one; in this mode, automatic mode makes any change of the selected reference clear the enable bit.

The alignment permit and the phase build-out disable request are registered outputs, so each reflects the inputs of the previous clock.

Top module: `fsync_qualifier`

## Requirements
- R1: While rst_n is low, en_bit, align_ok, pbo_off and en_hw_clr are all 0.
- R2: align_ok is 1 in a cycle only if, in the previous cycle, dpll_locked was 1, sync was enabled under the active mode, a valid pin was selected and that pin's sync_qual bit was 1; otherwise it is 0.
- R3: When src_sel[3:2] is not 2'b11, sync_pin is 1 (pin 1) in the same cycle, whatever the other inputs.
- R4: When src_sel[3:2] is 2'b11, sync_pin equals src_sel[1:0] if that value is 1 to 3; a value of 0 gives sync_pin 0 (no pin) and alignment stays off.
- R5: When src_sel[3:2] is 2'b11, sync is enabled only while en_bit is 1 and ref_idx equals the reference paired with the selected pin (by default pin 1 with reference 3, pin 2 with 4, pin 3 with 5).
- R6: When src_sel[3:2] is not 2'b11 and auto_mode is 1, sync is enabled only while en_bit is 1, dpll_locked is 1 and ref_idx equals src_sel.
- R7: When src_sel[3:2] is not 2'b11 and auto_mode is 0, sync is enabled exactly when en_bit is 1; src_sel and ref_idx have no effect.
- R8: When src_sel[3:2] is 2'b11 and auto_mode is 1, a change of ref_idx from its value on the previous clock raises en_hw_clr for that cycle and en_bit is 0 after the next edge, even if en_wr is 1 in the same cycle.
- R9: en_hw_clr stays 0 when src_sel[3:2] is not 2'b11, when auto_mode is 0, when ref_idx is unchanged, and in the first cycle after reset.
- R10: pbo_off is 1 in a cycle exactly when sync was enabled under the active mode in the previous cycle (R5 to R7).
- R11: Without a hardware clear, en_wr high loads en_wdata into en_bit at the next edge; with en_wr low en_bit holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 4 | Sync source selector (mode in [3:2], pin or reference index) |
| ref_idx | input | REF_W | Index of the reference selected by the DPLL |
| dpll_locked | input | 1 | DPLL lock status |
| auto_mode | input | 1 | Automatic enable mode |
| en_wr | input | 1 | Software write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| sync_qual | input | NUM_PINS | Per-pin sync qualified flags (bit 0 is pin 1) |
| en_bit | output | 1 | Current state of the sync enable bit |
| sync_pin | output | 2 | Selected sync pin, 1 to 3, 0 for none |
| align_ok | output | 1 | Registered alignment permit |
| en_hw_clr | output | 1 | One-cycle hardware clear of the enable bit |
| pbo_off | output | 1 | Registered request that phase build-out be off |

## Verification
The bench targets a reference change arriving in the same cycle as a software write of 1, where a design that ranked the write first would leave the enable bit set after a reference switch. It drives the selector through pin values 0 to 3 in multi-pin mode, where a design that treated 0 as pin 1 would permit alignment with no pin chosen, and it changes the selector and reference freely in manual single-pin mode, where a design that consulted them would drop the permit. Lock and qualification are removed for single cycles to catch a permit that is late or combinational, and the first cycle after reset is checked for a spurious clear pulse.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
   localparam int SRC_W = 4;
   typedef logic [1:0] pin_t;
   typedef enum logic [1:0] {
      MODE_ONE_MAN  = 2'd0,
      MODE_ONE_AUTO = 2'd1,
      MODE_MUL_MAN  = 2'd2,
      MODE_MUL_AUTO = 2'd3
   } fs_mode_e;
endpackage

// File: rtl/fsq_src_decode.sv
module fsq_src_decode
   import fsq_pkg::*;
#(
   parameter int NUM_PINS = 3
) (
   input  logic [SRC_W-1:0] src_sel,
   input  logic             auto_mode,
   output fs_mode_e         mode,
   output pin_t             pin,
   output logic             pin_valid
);
   logic multi;
   assign multi = src_sel[3] & src_sel[2];

   always_comb begin
      unique case ({multi, auto_mode})
         2'b00:   mode = MODE_ONE_MAN;
         2'b01:   mode = MODE_ONE_AUTO;
         2'b10:   mode = MODE_MUL_MAN;
         default: mode = MODE_MUL_AUTO;
      endcase
   end

   always_comb begin
      if (multi) begin
         pin_valid = (src_sel[1:0] != 2'd0) && (int'(src_sel[1:0]) <= NUM_PINS);
         pin       = pin_valid ? src_sel[1:0] : 2'd0;
      end else begin
         pin_valid = 1'b1;
         pin       = 2'd1;
      end
   end
endmodule

// File: rtl/fsq_ref_watch.sv
module fsq_ref_watch #(
   parameter int REF_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REF_W-1:0] ref_idx,
   output logic             changed
);
   logic [REF_W-1:0] ref_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         ref_q  <= ref_idx;
         seen_q <= 1'b1;
      end
   end

   assign changed = seen_q && (ref_q != ref_idx);
endmodule

// File: rtl/fsq_en_reg.sv
module fsq_en_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_clr,
   input  logic wr,
   input  logic wdata,
   output logic en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (hw_clr) en_q <= 1'b0;
      else if (wr)     en_q <= wdata;
   end
endmodule

// File: rtl/fsq_gate.sv
module fsq_gate
   import fsq_pkg::*;
#(
   parameter int                        REF_W    = 4,
   parameter int                        NUM_PINS = 3,
   parameter logic [NUM_PINS*REF_W-1:0] PIN_REF  = 12'h543
) (
   input  logic                clk,
   input  logic                rst_n,
   input  fs_mode_e            mode,
   input  pin_t                pin,
   input  logic                pin_valid,
   input  logic [SRC_W-1:0]    src_sel,
   input  logic [REF_W-1:0]    ref_idx,
   input  logic                dpll_locked,
   input  logic                en_q,
   input  logic [NUM_PINS-1:0] sync_qual,
   output logic                align_q,
   output logic                pbo_q
);
   logic [NUM_PINS-1:0] ref_hit;
   logic [NUM_PINS-1:0] qual_hit;
   logic                active;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic sel;
      assign sel         = (pin == pin_t'(i + 1));
      assign ref_hit[i]  = sel && (ref_idx == PIN_REF[i*REF_W +: REF_W]);
      assign qual_hit[i] = sel && sync_qual[i];
   end

   always_comb begin
      unique case (mode)
         MODE_ONE_MAN:  active = en_q;
         MODE_ONE_AUTO: active = en_q && dpll_locked && (ref_idx == REF_W'(src_sel));
         default:       active = en_q && pin_valid && (|ref_hit);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         align_q <= 1'b0;
         pbo_q   <= 1'b0;
      end else begin
         align_q <= dpll_locked && active && pin_valid && (|qual_hit);
         pbo_q   <= active;
      end
   end
endmodule

// File: rtl/fsync_qualifier.sv
module fsync_qualifier
   import fsq_pkg::*;
#(
   parameter int                        REF_W    = 4,
   parameter int                        NUM_PINS = 3,
   parameter logic [NUM_PINS*REF_W-1:0] PIN_REF  = 12'h543
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [3:0]          src_sel,
   input  logic [REF_W-1:0]    ref_idx,
   input  logic                dpll_locked,
   input  logic                auto_mode,
   input  logic                en_wr,
   input  logic                en_wdata,
   input  logic [NUM_PINS-1:0] sync_qual,
   output logic                en_bit,
   output logic [1:0]          sync_pin,
   output logic                align_ok,
   output logic                en_hw_clr,
   output logic                pbo_off
);
   if (NUM_PINS < 1 || NUM_PINS > 3) begin : g_bad_pins
      $error("fsync_qualifier: NUM_PINS must be 1 to 3");
   end
   if (REF_W < SRC_W) begin : g_bad_refw
      $error("fsync_qualifier: REF_W must be at least the selector width");
   end

   fs_mode_e mode;
   pin_t     pin;
   logic     pin_valid;
   logic     ref_changed;

   fsq_src_decode #(.NUM_PINS(NUM_PINS)) u_dec (
      .src_sel   (src_sel),
      .auto_mode (auto_mode),
      .mode      (mode),
      .pin       (pin),
      .pin_valid (pin_valid)
   );

   fsq_ref_watch #(.REF_W(REF_W)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_idx (ref_idx),
      .changed (ref_changed)
   );

   assign en_hw_clr = (mode == MODE_MUL_AUTO) && ref_changed;

   fsq_en_reg u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_clr (en_hw_clr),
      .wr     (en_wr),
      .wdata  (en_wdata),
      .en_q   (en_bit)
   );

   fsq_gate #(.REF_W(REF_W), .NUM_PINS(NUM_PINS), .PIN_REF(PIN_REF)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .pin         (pin),
      .pin_valid   (pin_valid),
      .src_sel     (src_sel),
      .ref_idx     (ref_idx),
      .dpll_locked (dpll_locked),
      .en_q        (en_bit),
      .sync_qual   (sync_qual),
      .align_q     (align_ok),
      .pbo_q       (pbo_off)
   );

   assign sync_pin = pin;
endmodule

// File: rtl/fsync_qualifier_chk.sv
module fsync_qualifier_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] src_sel,
   input logic       auto_mode,
   input logic       dpll_locked,
   input logic       en_bit,
   input logic [1:0] sync_pin,
   input logic       align_ok,
   input logic       en_hw_clr,
   input logic       pbo_off
);
   p_lock_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dpll_locked |=> !align_ok);

   p_single_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel[3:2] != 2'b11) |-> (sync_pin == 2'd1));

   p_no_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == 4'b1100) |=> !align_ok);

   p_manual_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel[3:2] != 2'b11 && !auto_mode) |=> (pbo_off == $past(en_bit)));

   p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en_hw_clr |=> !en_bit);

   p_no_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel[3:2] != 2'b11 || !auto_mode) |-> !en_hw_clr);
endmodule

bind fsync_qualifier fsync_qualifier_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_sel     (src_sel),
   .auto_mode   (auto_mode),
   .dpll_locked (dpll_locked),
   .en_bit      (en_bit),
   .sync_pin    (sync_pin),
   .align_ok    (align_ok),
   .en_hw_clr   (en_hw_clr),
   .pbo_off     (pbo_off)
);

// File: tb/fsync_qualifier_tb_top.sv
module fsync_qualifier_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] src_sel = '0;
   logic [3:0] ref_idx = '0;
   logic       dpll_locked = 1'b0;
   logic       auto_mode = 1'b0;
   logic       en_wr = 1'b0;
   logic       en_wdata = 1'b0;
   logic [2:0] sync_qual = '0;
   logic       en_bit, align_ok, en_hw_clr, pbo_off;
   logic [1:0] sync_pin;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   fsync_qualifier dut_i (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ref_idx(ref_idx),
      .dpll_locked(dpll_locked), .auto_mode(auto_mode), .en_wr(en_wr),
      .en_wdata(en_wdata), .sync_qual(sync_qual), .en_bit(en_bit),
      .sync_pin(sync_pin), .align_ok(align_ok), .en_hw_clr(en_hw_clr),
      .pbo_off(pbo_off)
   );

   // reference model state
   int m_en = 0, m_align = 0, m_pbo = 0, m_refq = 0, m_seen = 0;
   string m_alabel = "R2/R7";

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (!rst_n) begin
         chk("R1", "en_bit", int'(en_bit), 0);
         chk("R1", "align_ok", int'(align_ok), 0);
         chk("R1", "pbo_off", int'(pbo_off), 0);
         chk("R1", "en_hw_clr", int'(en_hw_clr), 0);
         m_en = 0; m_align = 0; m_pbo = 0; m_refq = 0; m_seen = 0;
      end else begin
         int src, lo, pin, exp_clr, act, qok, multi, nxt_en;
         src   = int'(src_sel);
         multi = (src >= 12);
         lo    = src % 4;
         pin   = multi ? ((lo >= 1 && lo <= 3) ? lo : 0) : 1;
         exp_clr = (multi && auto_mode && m_seen && (m_refq != int'(ref_idx))) ? 1 : 0;
         if (multi)           act = (pin != 0 && m_en && int'(ref_idx) == pin + 2);
         else if (!auto_mode) act = m_en;
         else                 act = (m_en && dpll_locked && int'(ref_idx) == src);
         qok = (pin != 0) && sync_qual[pin-1];
         // compare
         chk(multi ? "R4" : "R3", "sync_pin", int'(sync_pin), pin);
         chk(exp_clr ? "R8" : "R9", "en_hw_clr", int'(en_hw_clr), exp_clr);
         chk(m_alabel, "align_ok", int'(align_ok), m_align);
         chk("R10", "pbo_off", int'(pbo_off), m_pbo);
         chk("R11", "en_bit", int'(en_bit), m_en);
         // next state
         if (exp_clr)    nxt_en = 0;
         else if (en_wr) nxt_en = en_wdata;
         else            nxt_en = m_en;
         m_align = (dpll_locked && act && qok) ? 1 : 0;
         m_pbo   = act ? 1 : 0;
         m_alabel = multi ? "R2/R5" : (auto_mode ? "R2/R6" : "R2/R7");
         m_refq  = int'(ref_idx);
         m_seen  = 1;
         if (exp_clr) chk("R8", "clear beats write (pred)", nxt_en, 0);
         m_en = nxt_en;
      end
   end

   task automatic drive(input logic [3:0] s, input logic [3:0] r, input logic lk,
                        input logic am, input logic wr, input logic wd,
                        input logic [2:0] q, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         src_sel = s; ref_idx = r; dpll_locked = lk; auto_mode = am;
         en_wr = (k == 0) ? wr : 1'b0; en_wdata = wd; sync_qual = q;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      drive(4'd5, 4'd7, 1, 0, 1, 1, 3'b111, 3);   // R1: write ignored in reset
      @(negedge clk); rst_n = 1'b1;
      // R7 manual single: selector and reference have no effect
      drive(4'd0, 4'd7, 1, 0, 1, 1, 3'b001, 3);
      drive(4'd9, 4'd2, 1, 0, 0, 0, 3'b001, 3);
      drive(4'd9, 4'd2, 1, 0, 0, 0, 3'b000, 2);   // R2 qual lost
      drive(4'd9, 4'd2, 0, 0, 0, 0, 3'b001, 2);   // R2 lock lost
      drive(4'd9, 4'd2, 1, 0, 0, 0, 3'b001, 2);
      // R6 auto single
      drive(4'd3, 4'd3, 1, 1, 0, 0, 3'b001, 3);
      drive(4'd3, 4'd4, 1, 1, 0, 0, 3'b001, 3);
      drive(4'd4, 4'd4, 0, 1, 0, 0, 3'b001, 2);
      // R4/R5 multi manual across pins
      drive(4'd13, 4'd3, 1, 0, 0, 0, 3'b111, 3);
      drive(4'd14, 4'd4, 1, 0, 0, 0, 3'b111, 3);
      drive(4'd15, 4'd5, 1, 0, 0, 0, 3'b111, 3);
      drive(4'd15, 4'd5, 1, 0, 0, 0, 3'b011, 2);
      drive(4'd12, 4'd5, 1, 0, 0, 0, 3'b111, 3);
      drive(4'd14, 4'd3, 1, 0, 0, 0, 3'b111, 3);  // R9 change, manual: no clear
      // R8 multi auto
      drive(4'd14, 4'd4, 1, 1, 1, 1, 3'b111, 1);  // ref changes here: clear beats write
      drive(4'd14, 4'd4, 1, 1, 1, 1, 3'b111, 3);
      drive(4'd14, 4'd5, 1, 1, 0, 0, 3'b111, 2);
      drive(4'd15, 4'd5, 1, 1, 1, 1, 3'b111, 3);
      drive(4'd15, 4'd3, 1, 1, 1, 1, 3'b111, 2);
      // mixed pseudo-random traffic
      for (int i = 0; i < 600; i++) begin
         drive(4'($urandom_range(0, 15)), 4'($urandom_range(2, 6)),
               1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) != 0),
               3'($urandom_range(0, 7)), $urandom_range(1, 3));
      end
      @(negedge clk); rst_n = 1'b0;
      drive(4'd0, 4'd0, 0, 0, 0, 0, 3'b000, 2);
      @(negedge clk); @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule